// File: doc/BRIEF.md
# Conversion Duration Timer

This block measures, in system-clock cycles, how long one conversion of a decimating sinc filter takes. A start pulse clears a saturating counter and starts it. An end pulse, which marks the last serial sample of the conversion, stops it. The captured value is presented in a fixed-width register word, with the count aligned to the top bits. The counter runs on the system clock and not on the sample clock. Any stall between the two pulses, such as a channel that is switched off and on again, is therefore part of the measured time.

When the filter oversampling field is zero, the filter is bypassed and only the integrator runs. In that case the timer is held at zero and start pulses are ignored.

Alongside the timer, a reference calculator gives the number of input samples that the running configuration needs for one conversion. It takes the filter order, the filter and integrator oversampling fields, the filter type and the fast-continuous flags into account. A bench or a firmware model can compare the measured time against this figure. The block tracks internally whether the first conversion of a continuous run has finished, because fast mode only shortens the conversions that come after it.

Top module: `conv_dur_timer`

## Requirements
- R1: After reset the register word reads 0 and `busy_o` is 0. The count occupies the upper CNT_W bits of the REG_W-bit word, and the lower REG_W-CNT_W bits always read 0.
- R2: A start pulse that is accepted (enable high, oversampling field non-zero) sets the count to 0 and raises `busy_o` on the next edge. The count then rises by one on every later system-clock edge, up to and including the edge that samples the end pulse. An end pulse sampled N cycles after the start edge therefore leaves a count of N.
- R3: Idle cycles between start and end, of any length, are counted like any other cycle. The measured value is wall-clock time.
- R4: After the end pulse, `busy_o` falls and the count holds until the next accepted start. An end pulse while idle has no effect.
- R5: A start pulse while busy restarts the measurement from 0. When start and end arrive in the same cycle, the start wins.
- R6: While the oversampling field is 0 (bypass), the count is forced to 0, `busy_o` is 0, and start pulses are ignored.
- R7: While the enable is low, the count is forced to 0, `busy_o` is 0, and start pulses are ignored.
- R8: The count saturates at 2^CNT_W-1 and does not wrap.
- R9: For filter type 0 (sinc) of order F, with Fo = fosr field + 1 and Io = iosr field + 1, the expected length is Fo*(Io-1+F)+F samples. This holds whenever the shortened fast form does not apply.
- R10: For filter type 1 (fast sinc), the expected length is Fo*(Io+3)+2 samples, under the same conditions as R9.
- R11: With `cont_i` and `fast_i` both high, once one conversion has finished (an end pulse accepted while busy), the expected length becomes Fo*Io. Lowering `cont_i` or the enable returns it to the first-conversion form.
- R12: With the fosr field at 0, the expected length is Io, regardless of filter type or mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tmr_en_i | input | 1 | Timer enable |
| conv_start_i | input | 1 | Conversion start pulse |
| conv_end_i | input | 1 | Conversion end pulse (last serial sample) |
| fosr_i | input | FOSR_W | Filter oversampling field (ratio minus one, 0 = bypass) |
| iosr_i | input | IOSR_W | Integrator oversampling field (ratio minus one) |
| ford_i | input | 3 | Sinc filter order, 1 to 5 |
| ftype_i | input | 1 | Filter type: 0 sinc, 1 fast sinc |
| fast_i | input | 1 | Fast mode flag |
| cont_i | input | 1 | Continuous conversion mode |
| tmr_word_o | output | REG_W | Register word with the count in the upper bits |
| busy_o | output | 1 | Measurement in progress |
| exp_len_o | output | LEN_W | Expected conversion length in input samples |

## Verification
The hardest state to reach is saturation, because the default 28-bit counter would need hundreds of millions of cycles to fill. The bench therefore runs a second instance, with a 5-bit count in an 8-bit word, on the same stimulus. Every duration in the sweep is checked against min(N, 31) on that instance, so the wrap point is crossed many times. The shortened fast-continuous length is the other awkward case: it only appears after a finished conversion. The bench completes one real conversion with continuous mode on before it sweeps the calculator fields, and checks the first-conversion form both before that conversion and after continuous mode is dropped.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
   typedef enum logic {
      FT_SINC = 1'b0,
      FT_FAST = 1'b1
   } filt_type_e;

   localparam int unsigned ORD_W     = 3;
   localparam int unsigned FAST_K    = 4;  // order stand-in for the fast sinc type
   localparam int unsigned FAST_TAIL = 2;
endpackage

// File: rtl/cdt_sat_counter.sv
module cdt_sat_counter #(
   parameter int unsigned W = 28
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         inc_i,
   output logic [W-1:0] cnt_o
);
   localparam logic [W-1:0] MAX = {W{1'b1}};

   initial begin
      if (W < 2) $error("cdt_sat_counter: W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt_o <= '0;
      else if (clr_i)              cnt_o <= '0;
      else if (inc_i && cnt_o != MAX) cnt_o <= cnt_o + 1'b1;
   end
endmodule

// File: rtl/cdt_ctrl.sv
module cdt_ctrl #(
   parameter int unsigned FOSR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              start_i,
   input  logic              end_i,
   input  logic              cont_i,
   input  logic [FOSR_W-1:0] fosr_i,
   output logic              clr_o,
   output logic              inc_o,
   output logic              busy_o,
   output logic              seen_first_o
);
   logic kill;
   logic done;

   assign kill  = !en_i || (fosr_i == '0);
   assign clr_o = kill || start_i;
   assign inc_o = busy_o && !clr_o;
   assign done  = busy_o && end_i && !clr_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        busy_o <= 1'b0;
      else if (kill)     busy_o <= 1'b0;
      else if (start_i)  busy_o <= 1'b1;
      else if (done)     busy_o <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                seen_first_o <= 1'b0;
      else if (!en_i || !cont_i) seen_first_o <= 1'b0;
      else if (done)             seen_first_o <= 1'b1;
   end
endmodule

// File: rtl/cdt_len_calc.sv
module cdt_len_calc
   import cdt_pkg::*;
#(
   parameter int unsigned FOSR_W  = 10,
   parameter int unsigned IOSR_W  = 8,
   parameter int unsigned LEN_W   = 21,
   parameter bit          LEN_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FOSR_W-1:0] fosr_i,
   input  logic [IOSR_W-1:0] iosr_i,
   input  logic [ORD_W-1:0]  ford_i,
   input  filt_type_e        ftype_i,
   input  logic              short_i,
   output logic [LEN_W-1:0]  len_o
);
   logic [LEN_W-1:0] fo, io, ord, len_c;

   always_comb begin
      fo  = LEN_W'(fosr_i) + 1'b1;
      io  = LEN_W'(iosr_i) + 1'b1;
      ord = LEN_W'(ford_i);
      if (fosr_i == '0)
         len_c = io;
      else if (short_i)
         len_c = fo * io;
      else if (ftype_i == FT_FAST)
         len_c = fo * (io - 1'b1 + LEN_W'(FAST_K)) + LEN_W'(FAST_TAIL);
      else
         len_c = fo * (io - 1'b1 + ord) + ord;
   end

   generate
      if (LEN_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) len_o <= '0;
            else        len_o <= len_c;
         end
      end else begin : g_comb
         assign len_o = len_c;
      end
   endgenerate
endmodule

// File: rtl/conv_dur_timer.sv
module conv_dur_timer
   import cdt_pkg::*;
#(
   parameter int unsigned CNT_W   = 28,
   parameter int unsigned REG_W   = 32,
   parameter int unsigned FOSR_W  = 10,
   parameter int unsigned IOSR_W  = 8,
   parameter int unsigned LEN_W   = FOSR_W + IOSR_W + 3,
   parameter bit          LEN_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tmr_en_i,
   input  logic              conv_start_i,
   input  logic              conv_end_i,
   input  logic [FOSR_W-1:0] fosr_i,
   input  logic [IOSR_W-1:0] iosr_i,
   input  logic [2:0]        ford_i,
   input  logic              ftype_i,
   input  logic              fast_i,
   input  logic              cont_i,
   output logic [REG_W-1:0]  tmr_word_o,
   output logic              busy_o,
   output logic [LEN_W-1:0]  exp_len_o
);
   localparam int unsigned LOW_W = REG_W - CNT_W;

   initial begin
      if (CNT_W > REG_W)                  $error("conv_dur_timer: CNT_W exceeds REG_W");
      if (LEN_W < FOSR_W + IOSR_W + 3)    $error("conv_dur_timer: LEN_W too narrow");
      if (FOSR_W < 1 || IOSR_W < 1)       $error("conv_dur_timer: field widths must be positive");
   end

   logic             clr, inc, seen_first;
   logic [CNT_W-1:0] cnt;

   cdt_ctrl #(.FOSR_W(FOSR_W)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .en_i         (tmr_en_i),
      .start_i      (conv_start_i),
      .end_i        (conv_end_i),
      .cont_i       (cont_i),
      .fosr_i       (fosr_i),
      .clr_o        (clr),
      .inc_o        (inc),
      .busy_o       (busy_o),
      .seen_first_o (seen_first)
   );

   cdt_sat_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (clr),
      .inc_i (inc),
      .cnt_o (cnt)
   );

   cdt_len_calc #(
      .FOSR_W  (FOSR_W),
      .IOSR_W  (IOSR_W),
      .LEN_W   (LEN_W),
      .LEN_REG (LEN_REG)
   ) u_len (
      .clk     (clk),
      .rst_n   (rst_n),
      .fosr_i  (fosr_i),
      .iosr_i  (iosr_i),
      .ford_i  (ford_i),
      .ftype_i (filt_type_e'(ftype_i)),
      .short_i (fast_i && cont_i && seen_first),
      .len_o   (exp_len_o)
   );

   generate
      if (LOW_W == 0) begin : g_full
         assign tmr_word_o = cnt;
      end else begin : g_pad
         assign tmr_word_o = {cnt, {LOW_W{1'b0}}};
      end
   endgenerate
endmodule

// File: rtl/conv_dur_timer_chk.sv
module conv_dur_timer_chk #(
   parameter int unsigned CNT_W  = 28,
   parameter int unsigned REG_W  = 32,
   parameter int unsigned FOSR_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tmr_en_i,
   input logic              conv_start_i,
   input logic [FOSR_W-1:0] fosr_i,
   input logic              busy_o,
   input logic [REG_W-1:0]  tmr_word_o
);
   localparam logic [CNT_W-1:0] MAX = {CNT_W{1'b1}};
   logic [CNT_W-1:0] cnt;
   logic             live;
   assign cnt  = tmr_word_o[REG_W-1 -: CNT_W];
   assign live = tmr_en_i && (fosr_i != '0);

   // R2
   start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_start_i && live) |=> (cnt == '0 && busy_o));

   // R2
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && live && !conv_start_i && cnt != MAX) |=> (cnt == $past(cnt) + 1'b1));

   // R4
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && live && !conv_start_i) |=> $stable(cnt));

   // R6
   bypass_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fosr_i == '0) |=> (cnt == '0 && !busy_o));

   // R7
   disable_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tmr_en_i) |=> (cnt == '0 && !busy_o));

   // R8
   no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == MAX && live && !conv_start_i) |=> (cnt == MAX));
endmodule

bind conv_dur_timer conv_dur_timer_chk #(
   .CNT_W  (CNT_W),
   .REG_W  (REG_W),
   .FOSR_W (FOSR_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .tmr_en_i     (tmr_en_i),
   .conv_start_i (conv_start_i),
   .fosr_i       (fosr_i),
   .busy_o       (busy_o),
   .tmr_word_o   (tmr_word_o)
);

// File: tb/conv_dur_timer_tb.sv
module conv_dur_timer_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0, st = 1'b0, en_p = 1'b0, cont = 1'b0, fast = 1'b0, ftype = 1'b0;
   logic [9:0]  fosr = 10'd3;
   logic [7:0]  iosr = 8'd0;
   logic [2:0]  ford = 3'd3;
   logic [31:0] word;
   logic [7:0]  word_s;
   logic        busy, busy_s;
   logic [20:0] elen;
   logic [6:0]  elen_s;
   int n_run = 0, n_fail = 0;
   bit done = 0;

   always #5 clk = ~clk;

   conv_dur_timer u_dut (
      .clk(clk), .rst_n(rst_n), .tmr_en_i(en), .conv_start_i(st), .conv_end_i(en_p),
      .fosr_i(fosr), .iosr_i(iosr), .ford_i(ford), .ftype_i(ftype), .fast_i(fast),
      .cont_i(cont), .tmr_word_o(word), .busy_o(busy), .exp_len_o(elen));

   conv_dur_timer #(.CNT_W(5), .REG_W(8), .FOSR_W(2), .IOSR_W(2)) u_dut_sat (
      .clk(clk), .rst_n(rst_n), .tmr_en_i(en), .conv_start_i(st), .conv_end_i(en_p),
      .fosr_i(fosr[1:0] | 2'b01), .iosr_i(iosr[1:0]), .ford_i(ford), .ftype_i(ftype),
      .fast_i(fast), .cont_i(cont), .tmr_word_o(word_s), .busy_o(busy_s), .exp_len_o(elen_s));

   task automatic check(string req, longint act, longint exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic longint ref_len(int fo_f, int io_f, int f, bit ft, bit shrt);
      longint fo = fo_f + 1, io = io_f + 1;
      if (fo_f == 0) return io;
      if (shrt) return fo * io;
      if (ft) return fo * (io + 3) + 2;
      return fo * (io - 1 + f) + f;
   endfunction

   // start, then end sampled n edges later; leaves the bench just after that edge
   task automatic measure(int n);
      st = 1'b1;
      @(negedge clk); st = 1'b0;
      repeat (n - 1) @(negedge clk);
      en_p = 1'b1;
      @(negedge clk); en_p = 1'b0;
   endtask

   initial begin
      #1_500_000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset word", word, 0);
      check("R1 reset busy", busy, 0);
      rst_n = 1'b1;
      en = 1'b1;
      @(negedge clk);

      // R2 R8 duration sweep on both instances
      for (int n = 1; n <= 45; n++) begin
         measure(n);
         check("R2 count", word >> 4, n);
         check("R1 low bits", word[3:0], 0);
         check("R8 saturating", word_s >> 3, (n > 31) ? 31 : n);
         check("R4 busy low", busy, 0);
      end

      // R3 long stall inside one conversion
      measure(1000);
      check("R3 stall counted", word >> 4, 1000);

      // R4 hold and stray end
      repeat (20) @(negedge clk);
      en_p = 1'b1; @(negedge clk); en_p = 1'b0; @(negedge clk);
      check("R4 held", word >> 4, 1000);

      // R5 restart while busy, and start with end together
      st = 1'b1; @(negedge clk); st = 1'b0;
      repeat (9) @(negedge clk);
      check("R5 running", word >> 4, 9);
      st = 1'b1; en_p = 1'b1; @(negedge clk); st = 1'b0; en_p = 1'b0;
      check("R5 restart zero", word >> 4, 0);
      check("R5 start wins", busy, 1);
      repeat (4) @(negedge clk);
      en_p = 1'b1; @(negedge clk); en_p = 1'b0;
      check("R5 restarted count", word >> 4, 5);

      // R6 bypass
      fosr = 10'd0; @(negedge clk);
      check("R6 cleared", word >> 4, 0);
      st = 1'b1; @(negedge clk); st = 1'b0; repeat (3) @(negedge clk);
      check("R6 start ignored", busy, 0);
      check("R6 count zero", word >> 4, 0);
      fosr = 10'd3;
      st = 1'b1; @(negedge clk); st = 1'b0; repeat (5) @(negedge clk);
      fosr = 10'd0; @(negedge clk);
      check("R6 mid-conversion", word >> 4, 0);
      check("R6 busy dropped", busy, 0);
      fosr = 10'd3;

      // R7 enable low
      measure(7);
      en = 1'b0; @(negedge clk);
      check("R7 cleared", word >> 4, 0);
      st = 1'b1; @(negedge clk); st = 1'b0; @(negedge clk);
      check("R7 start ignored", busy, 0);
      en = 1'b1; @(negedge clk);

      // R9 R10 R12 calculator sweep, first-conversion form
      cont = 1'b0; fast = 1'b1;
      for (int a = 0; a < 8; a++)
         for (int b = 0; b < 8; b++)
            for (int f = 1; f <= 5; f++)
               for (int t = 0; t < 2; t++) begin
                  fosr = 10'(a); iosr = 8'(b); ford = 3'(f); ftype = t[0];
                  #1;
                  check(a == 0 ? "R12 bypass len" : (t != 0 ? "R10 fast sinc len" : "R9 sinc len"),
                        elen, ref_len(a, b, f, t[0], 1'b0));
               end
      @(negedge clk);

      // R11 fast continuous
      fosr = 10'd5; iosr = 8'd6; ford = 3'd2; ftype = 1'b0; cont = 1'b1; fast = 1'b1;
      @(negedge clk);
      check("R11 first conversion", elen, ref_len(5, 6, 2, 1'b0, 1'b0));
      measure(3);
      for (int a = 0; a < 8; a++)
         for (int b = 0; b < 8; b++)
            for (int t = 0; t < 2; t++) begin
               fosr = 10'(a); iosr = 8'(b); ftype = t[0];
               #1;
               check(a == 0 ? "R12 bypass in fast" : "R11 shortened", elen,
                     ref_len(a, b, 2, t[0], 1'b1));
            end
      fosr = 10'd5; iosr = 8'd6; ftype = 1'b0;
      fast = 1'b0; #1;
      check("R11 fast off", elen, ref_len(5, 6, 2, 1'b0, 1'b0));
      fast = 1'b1; #1;
      check("R11 fast back on", elen, ref_len(5, 6, 2, 1'b0, 1'b1));
      @(negedge clk); cont = 1'b0; @(negedge clk); cont = 1'b1; #1;
      check("R11 cont dropped", elen, ref_len(5, 6, 2, 1'b0, 1'b0));

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule